// File: doc/BRIEF.md
# Re-Reference Prediction Replacement Controller

This block picks the victim way for a set-associative cache and keeps the replacement state for every set. Each way of each set holds a 2-bit prediction of how soon it will be used again: 0 means very soon, 1 soon, 2 later and 3 distant. A hit pulls the way's prediction to 0. A miss looks for an invalid way first, then for a way predicted distant. If there is none, it ages the whole set by one step per cycle until a distant way shows up. The chosen way is then filled with an insertion prediction, and a one-cycle done strobe returns the victim. Tag and data arrays live outside the block.

Two insertion policies are available. The static policy inserts at 2, which keeps a working set safe from a one-off scan. The bimodal policy inserts at 3 nearly every time, which lets part of an oversized working set survive. A few leader sets always use one policy or the other. A saturating selector counter tracks which group of leaders misses more, and every other set, called a follower, uses the policy the selector currently favours.

Top module: `rrip_repl_ctrl`

## Requirements
- R1: After reset every prediction in every set is 3, `done` is low and `victim_way` is 0. The first miss to an untouched set with all ways valid therefore returns way 0 without aging.
- R2: When the valid mask has any bit clear, the lowest-numbered invalid way is the victim and no aging takes place.
- R3: When all ways are valid and at least one has prediction 3, the lowest-numbered way with prediction 3 is the victim and no aging takes place.
- R4: When no way is invalid or distant, each cycle adds 1 to every prediction in the set until a distant way appears. At most 3 such steps are needed. `done` rises 2 + a cycles after the cycle in which the miss is presented, where a is the number of aging steps.
- R5: A hit presented while idle sets that way's prediction to 0 at the next clock edge and produces no `done` pulse.
- R6: Static insertion writes prediction 2. It applies to the static leader sets (set index mod 32 equals 0) and to follower sets while the selector MSB is 0.
- R7: Bimodal insertion writes prediction 3, except on exactly one of every 31 consecutive bimodal fills, which writes 2. This approximates a 1-in-32 rate with a 5-bit maximal-length LFSR that advances once per bimodal fill. It applies to the bimodal leader sets (set index mod 32 equals 31) and to follower sets while the selector MSB is 1.
- R8: The 10-bit selector resets to 511. It adds 1 for each accepted miss in a static leader set and subtracts 1 for each accepted miss in a bimodal leader set, saturating at 0 and 1023, so a single step across 511/512 changes the follower policy.
- R9: `done` is a single-cycle pulse carrying the victim in `victim_way`. Any request presented while a miss is still being resolved is ignored, and a request is accepted again in the cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A lookup result is presented this cycle |
| req_hit | input | 1 | 1: hit on `req_way`; 0: miss, a victim is needed and will be filled |
| req_set | input | 6 | Set index of the access |
| req_way | input | 2 | Way that hit (ignored on a miss) |
| req_ways_valid | input | 4 | Valid bit of each way in the set (used on a miss) |
| victim_way | output | 2 | Way chosen for replacement, held until the next miss completes |
| done | output | 1 | One-cycle strobe: `victim_way` is valid and the fill has been recorded |

## Verification
A hit acts at the first clock edge after it is presented. A miss reports at the sampling point 2 + a cycles after presentation, where a is 3 minus the largest prediction in the set when all ways are valid and none is distant. The bench drives inputs on the falling edge and counts falling edges from the request until `done` is seen. Each latency is compared with the value predicted from the hits and fills that came before. Insertion values are never read directly. Instead, a probe sequence pulls every way but way 0 to 0, so the aging count of the next miss (1 or 0) reveals whether the previous fill into way 0 wrote 2 or 3. Selector moves are judged by the insertion behaviour of follower sets after a known number of leader misses.

// File: rtl/rrip_pkg.sv
package rrip_pkg;

    typedef logic [1:0] rrpv_t;

    localparam rrpv_t RRPV_NEAR    = 2'd0;
    localparam rrpv_t RRPV_LONG    = 2'd2;
    localparam rrpv_t RRPV_DISTANT = 2'd3;

    // bimodal chooser: 5-bit maximal-length LFSR, "long" insert on one state
    localparam int              LFSR_W    = 5;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 5'b10011;
    localparam logic [LFSR_W-1:0] LFSR_PICK = 5'b00001;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_HIT,
        WR_AGE,
        WR_FILL
    } wr_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_SEARCH
    } ctrl_state_e;

    typedef enum logic [1:0] {
        ROLE_FOLLOW,
        ROLE_LEAD_STATIC,
        ROLE_LEAD_BIMODAL
    } set_role_e;

    function automatic rrpv_t rrpv_age(input rrpv_t v);
        return (v == RRPV_DISTANT) ? v : rrpv_t'(v + 2'd1);
    endfunction

    // polynomial x^5 + x^3 + 1, period 31 from any nonzero state
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[3:0], s[4] ^ s[2]};
    endfunction

endpackage

// File: rtl/rrip_rrpv_store.sv
module rrip_rrpv_store
    import rrip_pkg::*;
#(
    parameter int NUM_SETS = 64,
    parameter int NUM_WAYS = 4,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  wr_op_e                     wr_op,
    input  logic [SET_W-1:0]           wr_set,
    input  logic [WAY_W-1:0]           wr_way,
    input  rrpv_t                      wr_val,
    input  logic [SET_W-1:0]           rd_set,
    output rrpv_t [NUM_WAYS-1:0]       rd_row
);

    rrpv_t [NUM_WAYS-1:0] mem_q [NUM_SETS];

    assign rd_row = mem_q[rd_set];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    mem_q[s][w] <= RRPV_DISTANT;
                end
            end
        end else begin
            case (wr_op)
                WR_HIT:  mem_q[wr_set][wr_way] <= RRPV_NEAR;
                WR_FILL: mem_q[wr_set][wr_way] <= wr_val;
                WR_AGE: begin
                    for (int w = 0; w < NUM_WAYS; w++) begin
                        mem_q[wr_set][w] <= rrpv_age(mem_q[wr_set][w]);
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rrip_way_pick.sv
module rrip_way_pick
    import rrip_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  rrpv_t [NUM_WAYS-1:0] row,
    input  logic  [NUM_WAYS-1:0] ways_valid,
    output logic                 inv_found,
    output logic [WAY_W-1:0]     inv_way,
    output logic                 dist_found,
    output logic [WAY_W-1:0]     dist_way
);

    logic [NUM_WAYS-1:0] is_inv;
    logic [NUM_WAYS-1:0] is_dist;

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_flag
        assign is_inv[g]  = ~ways_valid[g];
        assign is_dist[g] = (row[g] == RRPV_DISTANT);
    end

    assign inv_found  = |is_inv;
    assign dist_found = |is_dist;

    // scan from the top so the lowest matching index is the last written
    always_comb begin
        inv_way  = '0;
        dist_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (is_inv[w])  inv_way  = WAY_W'(w);
            if (is_dist[w]) dist_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/rrip_duel.sv
module rrip_duel
    import rrip_pkg::*;
#(
    parameter int DUEL_SPACING = 32,
    parameter int PSEL_W       = 10,
    localparam int DUEL_W = $clog2(DUEL_SPACING)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_take,
    input  logic [DUEL_W-1:0] miss_slot,
    input  logic              fill_fire,
    input  logic [DUEL_W-1:0] fill_slot,
    output rrpv_t             ins_val,
    output logic [PSEL_W-1:0] psel_o
);

    localparam logic [PSEL_W-1:0] PSEL_MAX  = {PSEL_W{1'b1}};
    localparam logic [PSEL_W-1:0] PSEL_INIT = {1'b0, {(PSEL_W-1){1'b1}}};

    logic [PSEL_W-1:0] psel_q;
    logic [LFSR_W-1:0] lfsr_q;
    set_role_e         miss_role;
    set_role_e         fill_role;
    logic              use_bimodal;

    function automatic set_role_e role_of(input logic [DUEL_W-1:0] slot);
        if (slot == '0)      return ROLE_LEAD_STATIC;
        else if (slot == '1) return ROLE_LEAD_BIMODAL;
        else                 return ROLE_FOLLOW;
    endfunction

    assign miss_role = role_of(miss_slot);
    assign fill_role = role_of(fill_slot);

    assign use_bimodal = (fill_role == ROLE_LEAD_BIMODAL) ||
                         ((fill_role == ROLE_FOLLOW) && psel_q[PSEL_W-1]);

    assign ins_val = !use_bimodal          ? RRPV_LONG :
                     (lfsr_q == LFSR_PICK) ? RRPV_LONG : RRPV_DISTANT;

    assign psel_o = psel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            psel_q <= PSEL_INIT;
        end else if (miss_take) begin
            if (miss_role == ROLE_LEAD_STATIC && psel_q != PSEL_MAX) begin
                psel_q <= psel_q + 1'b1;
            end else if (miss_role == ROLE_LEAD_BIMODAL && psel_q != '0) begin
                psel_q <= psel_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= LFSR_SEED;
        end else if (fill_fire && use_bimodal) begin
            lfsr_q <= lfsr_step(lfsr_q);
        end
    end

endmodule

// File: rtl/rrip_repl_ctrl.sv
module rrip_repl_ctrl
    import rrip_pkg::*;
#(
    parameter int NUM_SETS     = 64,
    parameter int NUM_WAYS     = 4,
    parameter int DUEL_SPACING = 32,
    parameter int PSEL_W       = 10,
    localparam int SET_W  = $clog2(NUM_SETS),
    localparam int WAY_W  = $clog2(NUM_WAYS),
    localparam int DUEL_W = $clog2(DUEL_SPACING)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_hit,
    input  logic [SET_W-1:0]    req_set,
    input  logic [WAY_W-1:0]    req_way,
    input  logic [NUM_WAYS-1:0] req_ways_valid,
    output logic [WAY_W-1:0]    victim_way,
    output logic                done
);

    ctrl_state_e          state_q;
    logic [SET_W-1:0]     lat_set_q;
    logic [NUM_WAYS-1:0]  lat_valid_q;
    logic                 done_q;
    logic [WAY_W-1:0]     victim_q;

    logic                 busy;
    logic                 take_hit;
    logic                 take_miss;

    rrpv_t [NUM_WAYS-1:0] row;
    logic                 inv_found;
    logic                 dist_found;
    logic [WAY_W-1:0]     inv_way;
    logic [WAY_W-1:0]     dist_way;

    logic                 found;
    logic [WAY_W-1:0]     found_way;
    logic                 fill_fire;
    rrpv_t                ins_val;
    logic [PSEL_W-1:0]    psel_w;

    wr_op_e               wr_op;
    logic [SET_W-1:0]     wr_set;
    logic [WAY_W-1:0]     wr_way;
    rrpv_t                wr_val;

    assign busy      = (state_q == ST_SEARCH);
    assign take_hit  = req_valid &&  req_hit && !busy;
    assign take_miss = req_valid && !req_hit && !busy;

    rrip_rrpv_store #(
        .NUM_SETS (NUM_SETS),
        .NUM_WAYS (NUM_WAYS)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_op  (wr_op),
        .wr_set (wr_set),
        .wr_way (wr_way),
        .wr_val (wr_val),
        .rd_set (lat_set_q),
        .rd_row (row)
    );

    rrip_way_pick #(
        .NUM_WAYS (NUM_WAYS)
    ) u_pick (
        .row        (row),
        .ways_valid (lat_valid_q),
        .inv_found  (inv_found),
        .inv_way    (inv_way),
        .dist_found (dist_found),
        .dist_way   (dist_way)
    );

    rrip_duel #(
        .DUEL_SPACING (DUEL_SPACING),
        .PSEL_W       (PSEL_W)
    ) u_duel (
        .clk       (clk),
        .rst       (rst),
        .miss_take (take_miss),
        .miss_slot (req_set[DUEL_W-1:0]),
        .fill_fire (fill_fire),
        .fill_slot (lat_set_q[DUEL_W-1:0]),
        .ins_val   (ins_val),
        .psel_o    (psel_w)
    );

    // victim choice: invalid first, then distant, otherwise age the set
    always_comb begin
        found     = 1'b0;
        found_way = '0;
        if (busy) begin
            if (inv_found) begin
                found     = 1'b1;
                found_way = inv_way;
            end else if (dist_found) begin
                found     = 1'b1;
                found_way = dist_way;
            end
        end
    end

    assign fill_fire = busy && found;

    always_comb begin
        wr_op  = WR_NONE;
        wr_set = req_set;
        wr_way = req_way;
        wr_val = RRPV_NEAR;
        if (take_hit) begin
            wr_op = WR_HIT;
        end else if (busy) begin
            wr_set = lat_set_q;
            if (found) begin
                wr_op  = WR_FILL;
                wr_way = found_way;
                wr_val = ins_val;
            end else begin
                wr_op = WR_AGE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            lat_set_q   <= '0;
            lat_valid_q <= '1;
            done_q      <= 1'b0;
            victim_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (take_miss) begin
                        state_q     <= ST_SEARCH;
                        lat_set_q   <= req_set;
                        lat_valid_q <= req_ways_valid;
                    end
                end
                ST_SEARCH: begin
                    if (found) begin
                        state_q  <= ST_IDLE;
                        done_q   <= 1'b1;
                        victim_q <= found_way;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done       = done_q;
    assign victim_way = victim_q;

endmodule

// File: rtl/rrip_repl_checker.sv
module rrip_repl_checker #(
    parameter int NUM_WAYS = 4,
    parameter int PSEL_W   = 10,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input logic                clk,
    input logic                rst,
    input logic                busy,
    input logic                done,
    input logic [WAY_W-1:0]    victim_way,
    input logic [NUM_WAYS-1:0] lat_valid,
    input logic [PSEL_W-1:0]   psel,
    input logic                take_hit
);

    localparam logic [PSEL_W-1:0] PSEL_TOP = {PSEL_W{1'b1}};

    logic [2:0] busy_run_q;

    always_ff @(posedge clk) begin
        if (rst)       busy_run_q <= '0;
        else if (busy) busy_run_q <= (busy_run_q == 3'd7) ? busy_run_q : busy_run_q + 3'd1;
        else           busy_run_q <= '0;
    end

    AST_SEARCH_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        busy |-> busy_run_q <= 3'd3); // R4

    AST_DONE_FROM_SEARCH: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy)); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (rst)
        (done && !(&lat_valid)) |-> !lat_valid[victim_way]); // R2

    AST_HIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        take_hit |=> !done); // R5

    AST_PSEL_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (psel == $past(psel)) || (psel == $past(psel) + 1'b1) ||
        (psel == $past(psel) - 1'b1)); // R8

    AST_PSEL_NO_WRAP_HI: assert property (@(posedge clk) disable iff (rst)
        ($past(psel) == PSEL_TOP) |-> (psel != '0)); // R8

    AST_PSEL_NO_WRAP_LO: assert property (@(posedge clk) disable iff (rst)
        ($past(psel) == '0) |-> (psel != PSEL_TOP)); // R8

endmodule

bind rrip_repl_ctrl rrip_repl_checker #(
    .NUM_WAYS (NUM_WAYS),
    .PSEL_W   (PSEL_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .victim_way (victim_way),
    .lat_valid  (lat_valid_q),
    .psel       (psel_w),
    .take_hit   (take_hit)
);

// File: tb/sim_rrip_repl_ctrl.sv
module sim_rrip_repl_ctrl;

    localparam int NS = 64;
    localparam int NW = 4;
    localparam int SW = $clog2(NS);
    localparam int WW = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_hit = 1'b0;
    logic [SW-1:0] req_set = '0;
    logic [WW-1:0] req_way = '0;
    logic [NW-1:0] req_ways_valid = '1;
    logic [WW-1:0] victim_way;
    logic          done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rrip_repl_ctrl u0 (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_hit        (req_hit),
        .req_set        (req_set),
        .req_way        (req_way),
        .req_ways_valid (req_ways_valid),
        .victim_way     (victim_way),
        .done           (done)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_hit(input int set, input int way, output int done_after);
        @(negedge clk);
        req_valid = 1'b1; req_hit = 1'b1;
        req_set = SW'(set); req_way = WW'(way);
        @(negedge clk);
        req_valid = 1'b0; req_hit = 1'b0;
        done_after = int'(done);
    endtask

    // returns victim and number of aging steps (latency - 2)
    task automatic do_miss(input int set, input logic [NW-1:0] vmask,
                           output int way, output int aging);
        int k = 0;
        bit seen = 0;
        @(negedge clk);
        req_valid = 1'b1; req_hit = 1'b0;
        req_set = SW'(set); req_ways_valid = vmask;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            k++;
            if (done) seen = 1;
        end
        if (!seen) check_eq("R9 done never seen", 0, 1);
        way   = int'(victim_way);
        aging = k - 2;
    endtask

    // probe: pull ways 1..NW-1 to 0, miss; the aging count reveals the value
    // the previous fill wrote into way 0 (1 -> wrote 2, 0 -> wrote 3)
    task automatic run_probe(input int set, input int iters,
                             output int longs, output int odd, output int wrong_way);
        int d, w, a;
        longs = 0; odd = 0; wrong_way = 0;
        for (int i = 0; i < iters; i++) begin
            for (int h = 1; h < NW; h++) do_hit(set, h, d);
            do_miss(set, '1, w, a);
            if (w != 0) wrong_way++;
            if (i == 0) begin
                if (a != 0) odd++;
            end else if (a == 1) longs++;
            else if (a != 0) odd++;
        end
    endtask

    task automatic t_reset();
        int w, a;
        check_eq("R1 done low after reset", int'(done), 0);
        check_eq("R1 victim_way zero after reset", int'(victim_way), 0);
        do_miss(3, '1, w, a);
        check_eq("R1 fresh set victim", w, 0);
        check_eq("R1 fresh set no aging", a, 0);
    endtask

    task automatic t_invalid_first();
        int d, w, a;
        for (int h = 0; h < NW; h++) do_hit(4, h, d);
        do_miss(4, 4'b0101, w, a);
        check_eq("R2 lowest invalid way", w, 1);
        check_eq("R2 no aging with invalid way", a, 0);
    endtask

    task automatic t_lowest_distant();
        int d, w, a;
        do_hit(5, 0, d);
        check_eq("R5 hit gives no done", d, 0);
        do_miss(5, '1, w, a);
        check_eq("R3 lowest distant way", w, 1);
        check_eq("R3 no aging with distant way", a, 0);
    endtask

    task automatic t_aging();
        int d, w, a;
        for (int h = 0; h < NW; h++) do_hit(6, h, d);
        do_miss(6, '1, w, a);
        check_eq("R4 all-near set ages three times", a, 3);
        check_eq("R4 victim after aging", w, 0);
        do_miss(6, '1, w, a);
        check_eq("R4 aged ways now distant", w, 1);
        check_eq("R4 no further aging", a, 0);
    endtask

    task automatic t_busy_ignore();
        int d, w, a;
        int pulses = 0;
        for (int h = 0; h < NW; h++) do_hit(12, h, d);
        @(negedge clk);
        req_valid = 1'b1; req_hit = 1'b0; req_set = SW'(12); req_ways_valid = '1;
        @(negedge clk);
        pulses += int'(done);
        req_set = SW'(13);
        @(negedge clk);
        pulses += int'(done);
        req_valid = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            pulses += int'(done);
        end
        check_eq("R9 one done pulse for one accepted miss", pulses, 1);
        check_eq("R9 victim of accepted miss", int'(victim_way), 0);
        do_miss(13, '1, w, a);
        check_eq("R9 ignored miss left set untouched", w, 0);
    endtask

    task automatic t_static_follower(input int set, input string tag);
        int l, o, ww;
        run_probe(set, 4, l, o, ww);
        check_eq({tag, " follower static fills write 2"}, l, 3);
        check_eq({tag, " probe aging counts"}, o, 0);
        check_eq({tag, " probe victim way 0"}, ww, 0);
    endtask

    task automatic t_flip_up();
        int w, a, l, o, ww;
        do_miss(32, '1, w, a);           // selector 511 -> 512
        run_probe(9, 32, l, o, ww);
        check_eq("R8 one static leader miss flips followers; R7 one long in 31", l, 1);
        check_eq("R7 probe aging counts", o, 0);
        check_eq("R7 probe victim way 0", ww, 0);
    endtask

    task automatic t_static_leader();
        int l, o, ww;
        run_probe(0, 63, l, o, ww);      // selector 512 -> 575
        check_eq("R6 static leader every fill writes 2", l, 62);
        check_eq("R6 probe aging counts", o, 0);
        check_eq("R6 probe victim way 0", ww, 0);
    endtask

    task automatic t_bimodal_leader();
        int l, o, ww;
        run_probe(31, 63, l, o, ww);     // selector 575 -> 512
        check_eq("R7 bimodal leader two longs in 62 fills", l, 2);
        check_eq("R7 probe aging counts", o, 0);
        check_eq("R7 probe victim way 0", ww, 0);
    endtask

    task automatic t_flip_down();
        int w, a;
        do_miss(63, '1, w, a);           // selector 512 -> 511
        t_static_follower(10, "R8 step back below midpoint:");
    endtask

    task automatic t_saturate();
        int w, a;
        for (int i = 0; i < 600; i++) do_miss(63, '1, w, a);   // floor at 0
        t_static_follower(11, "R8 selector saturates at zero:");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_invalid_first();
        t_lowest_distant();
        t_aging();
        t_busy_ignore();
        t_static_follower(8, "R6");
        t_flip_up();
        t_static_leader();
        t_bimodal_leader();
        t_flip_down();
        t_saturate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule